// File: doc/BRIEF.md
# Iterative AES Block Encryptor

This block encrypts one 128-bit block at a time with the AES cipher. It works through the rounds one after another on a single state register, which it treats as a 4x4 byte array. Each round takes two clock cycles. In the first cycle all sixteen state bytes go through the substitution table, and the results are registered. In the second cycle the rows are rotated, the columns are mixed and the round key is XORed in, and the result is written back to the state. The substitution and the two constant field multiplies used in column mixing (by 2 and by 3) come from 256-entry lookup tables with an 8-bit address and 8-bit data. The table contents are computed from the field arithmetic and are not stored as literals.

A separate key-expansion unit supplies the round keys. The encryptor drives a round-key index, and the expansion unit returns the matching 128-bit round key on the same cycle. A start pulse loads the plaintext, XORed with round key 0, and latches the key-length select. After all rounds the ciphertext is on the output and a one-cycle completion pulse is given. The selected key length sets the number of rounds.

Top module: `aes_iter_encrypt`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and `rk_idx_o` is 0.
- R2: While idle, `rk_idx_o` is 0. An accepted start loads the state with `pt_i XOR rk_i`, so round key 0 is applied before the first round.
- R3: Key select 2'b00 selects a 128-bit key and 10 rounds. The result matches the standard AES-128 ciphertext.
- R4: Key select 2'b01 selects a 192-bit key and 12 rounds. The result matches the standard AES-192 ciphertext.
- R5: Key select 2'b10 selects a 256-bit key and 14 rounds. The result matches the standard AES-256 ciphertext.
- R6: `done_o` first goes high exactly 2*Nr clock edges after the edge that accepted start, which gives 20, 24 and 28 cycles.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. `ct_o` holds the ciphertext unchanged until the next accepted start.
- R8: A start seen while `busy_o` is high is ignored. The running block's result and latency do not change, and no new run begins, even on the final busy cycle.
- R9: Bytes are big-endian. `pt_i[127:120]` is state row 0, column 0, and the following bytes fill the state column by column. `ct_o` and `rk_i` use the same order.
- R10: Key select 2'b11 behaves as 2'b10, with 14 rounds.
- R11: During both cycles of round r (r = 1..Nr), `rk_idx_o` equals r. In the final round the index therefore reaches Nr for exactly two cycles.
- R12: A start given in the cycle where `done_o` is high is accepted, and a new block begins back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request; acted on only when not busy |
| ksel_i | input | 2 | Key length select: 00=128, 01=192, 10/11=256 |
| pt_i | input | 128 | Plaintext block, big-endian bytes |
| rk_i | input | 128 | Round key for index `rk_idx_o`, from the key-expansion unit |
| rk_idx_o | output | 4 | Round-key index requested this cycle |
| busy_o | output | 1 | High while rounds are in progress |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ct_o | output | 128 | Ciphertext block, big-endian bytes |

## Verification
Two controller events can fall on the same clock edge: the last round finishing and a new start request arriving. The bench provokes this twice. In the first case, start is raised on the final busy cycle. The check is that the request is dropped, the ciphertext is correct, and `busy_o` stays low after the pulse. In the second case, start is raised in the cycle where `done_o` is high. The check is that the second block is accepted at once, uses its own key length, and completes with the correct latency and ciphertext.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  localparam int BLK_W  = 128;
  localparam int NBYTES = BLK_W / 8;
  localparam int RND_W  = 4;
  localparam int LAT_W  = RND_W + 2;

  typedef enum logic [1:0] {
    KSEL_128     = 2'd0,
    KSEL_192     = 2'd1,
    KSEL_256     = 2'd2,
    KSEL_256_ALT = 2'd3
  } ksel_e;

  typedef enum logic [1:0] {
    LUT_SUB = 2'd0,
    LUT_DBL = 2'd1,
    LUT_TRI = 2'd2
  } lut_kind_e;

  // multiply by x in GF(2^8) with the AES reduction polynomial
  function automatic logic [7:0] gf_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa, bb;
    p  = '0;
    aa = a;
    bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) p = p ^ aa;
      aa = gf_xt(aa);
      bb = {1'b0, bb[7:1]};
    end
    return p;
  endfunction

  // inverse as a^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] acc, base;
    logic [7:0] expo;
    acc  = 8'h01;
    base = a;
    expo = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (expo[i]) acc = gf_mul(acc, base);
      base = gf_mul(base, base);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] a, input int n);
    logic [7:0] r;
    r = a;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
  endfunction

  // table content as a function of address, one per table kind
  function automatic logic [7:0] lut_read(input lut_kind_e kind, input logic [7:0] a);
    logic [7:0] d;
    case (kind)
      LUT_SUB: d = sub_byte(a);
      LUT_DBL: d = gf_xt(a);
      LUT_TRI: d = gf_xt(a) ^ a;
      default: d = a;
    endcase
    return d;
  endfunction

  function automatic logic [RND_W-1:0] rounds_for(input logic [1:0] ks);
    logic [RND_W-1:0] n;
    case (ks)
      KSEL_128: n = RND_W'(10);
      KSEL_192: n = RND_W'(12);
      default:  n = RND_W'(14);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aes_byte_lut.sv
module aes_byte_lut
  import aes_iter_pkg::*;
#(
  parameter lut_kind_e KIND = LUT_SUB
) (
  input  logic [7:0] addr_i,
  output logic [7:0] data_o
);

  always_comb begin
    data_o = lut_read(KIND, addr_i);
  end

endmodule

// File: rtl/aes_sub_stage.sv
module aes_sub_stage
  import aes_iter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [BLK_W-1:0] st_i,
  output logic [BLK_W-1:0] sub_o
);

  logic [7:0] lut_d [NBYTES];
  logic [7:0] sub_q [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    aes_byte_lut #(.KIND(LUT_SUB)) i_sub_lut (
      .addr_i (st_i[BLK_W-1-8*i -: 8]),
      .data_o (lut_d[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sub_q[i] <= '0;
      end else if (en_i) begin
        sub_q[i] <= lut_d[i];
      end
    end

    assign sub_o[BLK_W-1-8*i -: 8] = sub_q[i];
  end

endmodule

// File: rtl/aes_mix_stage.sv
module aes_mix_stage
  import aes_iter_pkg::*;
(
  input  logic [BLK_W-1:0] sub_i,
  input  logic [BLK_W-1:0] rk_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] nxt_o
);

  logic [7:0] sr_b  [NBYTES];
  logic [7:0] dbl_b [NBYTES];
  logic [7:0] tri_b [NBYTES];
  logic [7:0] mc_b  [NBYTES];

  // byte k = 4*col + row; row r takes its byte from column (c + r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c + r) % 4) + r;

      assign sr_b[DST] = sub_i[BLK_W-1-8*SRC -: 8];

      aes_byte_lut #(.KIND(LUT_DBL)) i_dbl_lut (
        .addr_i (sr_b[DST]),
        .data_o (dbl_b[DST])
      );

      aes_byte_lut #(.KIND(LUT_TRI)) i_tri_lut (
        .addr_i (sr_b[DST]),
        .data_o (tri_b[DST])
      );
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_mix
    for (genvar r = 0; r < 4; r++) begin : g_out
      localparam int K0 = 4 * c + r;
      localparam int K1 = 4 * c + (r + 1) % 4;
      localparam int K2 = 4 * c + (r + 2) % 4;
      localparam int K3 = 4 * c + (r + 3) % 4;

      assign mc_b[K0] = dbl_b[K0] ^ tri_b[K1] ^ sr_b[K2] ^ sr_b[K3];

      assign nxt_o[BLK_W-1-8*K0 -: 8] =
        (last_i ? sr_b[K0] : mc_b[K0]) ^ rk_i[BLK_W-1-8*K0 -: 8];
    end
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_iter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       ksel_i,
  output logic             load_o,
  output logic             sub_en_o,
  output logic             mix_en_o,
  output logic             last_o,
  output logic [RND_W-1:0] rk_idx_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             busy_q, busy_n;
  logic             ph_q, ph_n;
  logic [RND_W-1:0] rnd_q, rnd_n;
  logic [RND_W-1:0] nr_q, nr_n;
  logic             done_q, done_n;

  assign load_o   = start_i && !busy_q;
  assign sub_en_o = busy_q && !ph_q;
  assign mix_en_o = busy_q && ph_q;
  assign last_o   = (rnd_q == nr_q);
  assign rk_idx_o = busy_q ? rnd_q : '0;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    rnd_n  = rnd_q;
    nr_n   = nr_q;
    done_n = 1'b0;
    if (load_o) begin
      busy_n = 1'b1;
      ph_n   = 1'b0;
      rnd_n  = RND_W'(1);
      nr_n   = rounds_for(ksel_i);
    end else if (busy_q) begin
      if (!ph_q) begin
        ph_n = 1'b1;
      end else begin
        ph_n = 1'b0;
        if (last_o) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          rnd_n = rnd_q + RND_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      rnd_q  <= '0;
      nr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      rnd_q  <= rnd_n;
      nr_q   <= nr_n;
      done_q <= done_n;
    end
  end

  // cycle counter from accepted start, used only by the latency check
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (load_o) begin
      lat_q <= '0;
    end else if (busy_q) begin
      lat_q <= lat_q + LAT_W'(1);
    end
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lat_q == {1'b0, nr_q, 1'b0}));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(ph_q && last_o)) |=> (busy_q && $stable(nr_q)));

  // R11
  rk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rk_idx_o != '0 && rk_idx_o <= nr_q));

endmodule

// File: rtl/aes_iter_encrypt.sv
module aes_iter_encrypt
  import aes_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         ksel_i,
  input  logic [BLK_W-1:0]   pt_i,
  input  logic [BLK_W-1:0]   rk_i,
  output logic [RND_W-1:0]   rk_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [BLK_W-1:0]   ct_o
);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic             load, sub_en, mix_en, last;
  logic [BLK_W-1:0] state_q, state_n;
  logic [BLK_W-1:0] sub_st, mix_st;

  aes_round_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .ksel_i   (ksel_i),
    .load_o   (load),
    .sub_en_o (sub_en),
    .mix_en_o (mix_en),
    .last_o   (last),
    .rk_idx_o (rk_idx_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  aes_sub_stage i_sub (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (sub_en),
    .st_i  (state_q),
    .sub_o (sub_st)
  );

  aes_mix_stage i_mix (
    .sub_i  (sub_st),
    .rk_i   (rk_i),
    .last_i (last),
    .nxt_o  (mix_st)
  );

  always_comb begin
    state_n = state_q;
    if (load) begin
      state_n = pt_i ^ rk_i;
    end else if (mix_en) begin
      state_n = mix_st;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_n;
    end
  end

  assign ct_o = state_q;

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_o);

  // R7
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !start_i) |=> $stable(ct_o));

  // R2
  load_key0_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |-> (rk_idx_o == '0));

endmodule

// File: tb/test_aes_iter_encrypt.sv
`timescale 1ns/1ps
module test_aes_iter_encrypt;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   ksel_i;
  logic [127:0] pt_i;
  logic [127:0] rk_i;
  logic [3:0]   rk_idx_o;
  logic         busy_o;
  logic         done_o;
  logic [127:0] ct_o;

  always #2.5 clk = ~clk;

  aes_iter_encrypt i_aes_iter_encrypt (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ksel_i(ksel_i),
    .pt_i(pt_i), .rk_i(rk_i), .rk_idx_o(rk_idx_o),
    .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the key-expansion unit
  logic [7:0]  tb_sb [256];
  logic [31:0] kw [60];

  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = m_xt(x);
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int b = 1; b < 256; b++)
        if (m_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      s = 8'h63;
      for (int k = 0; k < 5; k++) s ^= ((inv << k) | (inv >> (8 - k)));
      tb_sb[a] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {tb_sb[w[31:24]], tb_sb[w[23:16]], tb_sb[w[15:8]], tb_sb[w[7:0]]};
  endfunction

  task automatic expand(input logic [255:0] key, input logic [1:0] ks);
    int nk = (ks == 2'd0) ? 4 : (ks == 2'd1) ? 6 : 8;
    int nr = nk + 6;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 60; i++) kw[i] = '0;
    for (int i = 0; i < nk; i++) kw[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4 * (nr + 1); i++) begin
      logic [31:0] t = kw[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m_xt(rc);
      end else if (nk == 8 && i % 8 == 4) begin
        t = subw(t);
      end
      kw[i] = kw[i-nk] ^ t;
    end
  endtask

  always_comb begin
    rk_i = {kw[4*rk_idx_o], kw[4*rk_idx_o+1], kw[4*rk_idx_o+2], kw[4*rk_idx_o+3]};
  end

  // vectors: key (left aligned), key select, plaintext, ciphertext
  localparam int NV = 5;
  localparam logic [255:0] V_KEY [NV] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h0},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0},
    {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0},
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f
  };
  localparam logic [1:0] V_KS [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [127:0] V_PT [NV] = '{
    128'h00112233445566778899aabbccddeeff,
    128'h3243f6a8885a308d313198a2e0370734,
    128'h00112233445566778899aabbccddeeff,
    128'h00112233445566778899aabbccddeeff,
    128'h00112233445566778899aabbccddeeff
  };
  localparam logic [127:0] V_CT [NV] = '{
    128'h69c4e0d86a7b0430d8cdb78070b4c55a,
    128'h3925841d02dc09fbdc118597196a0b32,
    128'hdda97ca4864cdfe06eaf70a0ec0d7191,
    128'h8ea2b7ca516745bfeafc49904b496089,
    128'h8ea2b7ca516745bfeafc49904b496089
  };
  localparam string V_REQ [NV] = '{"R3", "R3/R9", "R4", "R5", "R10"};

  // call at a negedge; sets up inputs and raises start
  task automatic launch(input int v);
    expand(V_KEY[v], V_KS[v]);
    pt_i    = V_PT[v];
    ksel_i  = V_KS[v];
    start_i = 1'b1;
  endtask

  // mode 0: quiet, 1: start mid-run, 2: start on final busy cycle
  task automatic run_wait(input int v, input int mode);
    int nr  = (V_KS[v] == 2'd0) ? 10 : (V_KS[v] == 2'd1) ? 12 : 14;
    int cnt = 0;
    int top_cnt = 0;
    bit seen = 0;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start_i = 1'b0;
      if (rk_idx_o == 4'(nr)) top_cnt++;
      if (done_o) begin
        seen = 1;
      end else if ((mode == 1 && cnt == 5) || (mode == 2 && cnt == 2 * nr - 1)) begin
        start_i = 1'b1;
        pt_i    = ~pt_i;
        ksel_i  = 2'd0;
      end
    end
    chk(seen && cnt == 2 * nr, "R6 latency", 128'(cnt), 128'(2 * nr));
    chk(ct_o == V_CT[v], V_REQ[v], ct_o, V_CT[v]);
    if (mode == 0) chk(top_cnt == 2, "R11 final index cycles", 128'(top_cnt), 128'd2);
    if (mode != 0) chk(ct_o == V_CT[v], "R8 start while busy ignored", ct_o, V_CT[v]);
  endtask

  initial begin
    #(190000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    build_sbox();
    for (int i = 0; i < 60; i++) kw[i] = '0;
    rst_n = 1'b0; start_i = 1'b0; ksel_i = 2'd0; pt_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && rk_idx_o == 0, "R1 reset state",
        {busy_o, done_o, rk_idx_o}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && rk_idx_o == 0, "R1 after release",
        {busy_o, done_o, rk_idx_o}, 128'd0);

    for (int v = 0; v < NV; v++) begin
      launch(v);
      run_wait(v, 0);
      @(negedge clk);
      chk(!done_o, "R7 done single cycle", 128'(done_o), 128'd0);
      chk(rk_idx_o == 0, "R2 idle index zero", 128'(rk_idx_o), 128'd0);
    end

    // ciphertext held while idle
    repeat (5) @(negedge clk);
    chk(ct_o == V_CT[NV-1], "R7 ciphertext held", ct_o, V_CT[NV-1]);

    // start mid-run is ignored
    launch(2);
    run_wait(2, 1);

    // start on final busy cycle is dropped; no new run follows
    launch(0);
    run_wait(0, 2);
    @(negedge clk);
    chk(!busy_o, "R8 no run after final-cycle start", 128'(busy_o), 128'd0);
    repeat (3) @(negedge clk);
    chk(ct_o == V_CT[0], "R8 state untouched", ct_o, V_CT[0]);

    // back-to-back: start in the done cycle is accepted
    launch(1);
    run_wait(1, 0);
    launch(3);
    chk(!busy_o, "R12 idle in done cycle", 128'(busy_o), 128'd0);
    run_wait(3, 0);
    start_i = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule